// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel

This block is one channel of a bus-master DMA engine that moves sector data between a disk drive's 16-bit data port and system memory. It has no internal buffer. Software first builds a table of scatter/gather descriptors in memory. It then writes the table's base address into the channel's pointer register. Finally it writes the command register with the start bit set, and with the direction bit saying whether data flows toward memory or toward the drive.

Once started, the channel fetches one descriptor at a time. Each descriptor is two 32-bit words: the buffer address, then the byte count, whose top bit flags the last entry. For every 16-bit unit, the channel waits for the drive's request line and answers it with a one-cycle acknowledge. It then moves the unit to or from memory as a single halfword access on a 32-bit memory bus with byte enables. When the last entry's bytes are used up, the channel goes idle by itself. Software can also stop it at any moment by clearing the start bit.

The status register reports four things: activity, a bus error, the drive's interrupt and table completion. The error, interrupt and completion bits are sticky and are cleared by writing ones. The interrupt output follows the sticky interrupt bit. Each channel decodes an 8-byte register window. A second channel is a second instance whose window begins 8 bytes higher; the system decoder picks the channel with address bit 3.

Top module: `bmdma_channel`

## Requirements
- R1: After reset, every register offset 0..7 reads 0, `irq` is 0, and neither `mem_req` nor `drv_dmack` is asserted.
- R2: Offset 0 reads back the start bit (bit 0) and the direction bit (bit 3); its other bits read 0. Offsets 4..7 hold the table pointer, least significant byte at offset 4, and pointer bits 1:0 always read 0. Offsets 1 and 3 read 0.
- R3: A write to offset 0 with bit 0 set while the channel is idle makes status bit 0 (active) read 1 from the next cycle. In that cycle the channel requests a read of the word at the table pointer. The count word is read at pointer+4, and the next descriptor starts at pointer+8.
- R4: With direction bit 3 = 1, each acknowledged unit from `drv_rdata` is written to memory at consecutive halfword addresses that start at the descriptor address with bit 0 ignored. The byte enables are 0011 when address bit 1 is 0 and 1100 when it is 1.
- R5: With direction bit 3 = 0, halfwords read from memory at the same address sequence are presented on `drv_wdata`, one per acknowledge, in order.
- R6: The byte count is bits CNT_W-1:0 of the count word, with bit 0 ignored. Bits CNT_W..30 are ignored. A count of zero means 2^CNT_W bytes.
- R7: When the bytes of the descriptor whose count word has bit 31 set are exhausted, active clears and status bit 5 (end) sets. No further acknowledge or memory request follows, even while the drive keeps requesting.
- R8: A write to offset 0 with bit 0 clear stops a running transfer: from the next cycle active reads 0 and no further acknowledge or memory request is made.
- R9: A memory bus error response sets status bit 1, clears active, and stops the transfer.
- R10: Status bit 2 is set in every cycle after one in which `drv_intrq` is high, and `irq` equals status bit 2.
- R11: Status bits 1, 2 and 5 clear when a 1 is written to them at offset 2. Writing 0 leaves them unchanged, and a set condition in the same cycle wins over the clear.
- R12: A complete transfer, followed by the drive's interrupt, leaves status bits 2:0 at 100b.
- R13: `drv_dmack` is asserted only in a cycle where `drv_dmarq` is high, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register byte offset within the channel window |
| reg_we | input | 1 | Register byte write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt, high while status bit 2 is set |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_be | output | 4 | Byte enables for the access |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_err | input | 1 | Memory access failed, valid with `mem_ack` |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| drv_dmarq | input | 1 | Drive requests a data unit transfer |
| drv_dmack | output | 1 | Unit transferred in this cycle |
| drv_wdata | output | 16 | Data toward the drive |
| drv_rdata | input | 16 | Data from the drive |
| drv_intrq | input | 1 | Drive interrupt line |

## Verification
The bench builds the channel with CNT_W = 6, so a zero count stands for only 64 bytes. At that size a full-size descriptor and its wrap case run within a few hundred cycles. It sweeps both directions, with one to three descriptors, even and odd start addresses, both halfword lanes, ignored high count bits and a paced request line. For each case it predicts every memory halfword or drive word arithmetically. Separate cases cover stopping mid-table, a bus error on a chosen write, and the write-one-to-clear rules against a held interrupt.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    typedef enum logic [2:0] {
        W_IDLE,
        W_DESC_A,
        W_DESC_C,
        W_MEM_RD,
        W_DRV,
        W_MEM_WR
    } walk_e;

    localparam logic [2:0] OFS_CMD  = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd2;
    localparam logic [2:0] OFS_PTR0 = 3'd4;
    localparam logic [2:0] OFS_PTR1 = 3'd5;
    localparam logic [2:0] OFS_PTR2 = 3'd6;
    localparam logic [2:0] OFS_PTR3 = 3'd7;

    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;
    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_IRQ  = 2;
    localparam int ST_END  = 5;

    localparam int LAST_BIT = 31;

endpackage

// File: rtl/bmdma_lane.sv
module bmdma_lane (
    input  logic        hi_sel_i,
    input  logic [15:0] half_i,
    input  logic [31:0] word_i,
    output logic [3:0]  be_o,
    output logic [31:0] wdata_o,
    output logic [15:0] half_o
);
    // A halfword unit occupies one lane of the 32-bit word; address bit 1 picks it.
    always_comb begin
        wdata_o = {half_i, half_i};
        if (hi_sel_i) begin
            be_o   = 4'b1100;
            half_o = word_i[31:16];
        end else begin
            be_o   = 4'b0011;
            half_o = word_i[15:0];
        end
    end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr_i,
    input  logic        reg_we_i,
    input  logic [7:0]  reg_wdata_i,
    output logic [7:0]  reg_rdata_o,
    input  logic        active_i,
    input  logic        fault_i,
    input  logic        finish_i,
    input  logic        drv_intrq_i,
    output logic        go_o,
    output logic        go_dir_o,
    output logic        stop_o,
    output logic [31:0] tbl_ptr_o,
    output logic        irq_o
);
    typedef struct packed {
        logic        start;
        logic        dir;
        logic [31:0] ptr;
        logic        err;
        logic        intr;
        logic        fin;
    } regs_t;

    regs_t q, d;
    logic  cmd_wr, st_wr;

    always_comb begin
        d      = q;
        cmd_wr = reg_we_i && (reg_addr_i == OFS_CMD);
        st_wr  = reg_we_i && (reg_addr_i == OFS_STAT);

        if (cmd_wr) begin
            d.start = reg_wdata_i[CMD_GO];
            d.dir   = reg_wdata_i[CMD_DIR];
        end

        if (reg_we_i) begin
            case (reg_addr_i)
                OFS_PTR0: d.ptr[7:0]   = reg_wdata_i;
                OFS_PTR1: d.ptr[15:8]  = reg_wdata_i;
                OFS_PTR2: d.ptr[23:16] = reg_wdata_i;
                OFS_PTR3: d.ptr[31:24] = reg_wdata_i;
                default: ;
            endcase
        end
        d.ptr[1:0] = 2'b00;

        // Write-one-to-clear first, so that a same-cycle set wins.
        if (st_wr) begin
            if (reg_wdata_i[ST_ERR]) d.err  = 1'b0;
            if (reg_wdata_i[ST_IRQ]) d.intr = 1'b0;
            if (reg_wdata_i[ST_END]) d.fin  = 1'b0;
        end
        if (fault_i)     d.err  = 1'b1;
        if (drv_intrq_i) d.intr = 1'b1;
        if (finish_i)    d.fin  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata_o = 8'h00;
        case (reg_addr_i)
            OFS_CMD: begin
                reg_rdata_o[CMD_GO]  = q.start;
                reg_rdata_o[CMD_DIR] = q.dir;
            end
            OFS_STAT: begin
                reg_rdata_o[ST_ACT] = active_i;
                reg_rdata_o[ST_ERR] = q.err;
                reg_rdata_o[ST_IRQ] = q.intr;
                reg_rdata_o[ST_END] = q.fin;
            end
            OFS_PTR0: reg_rdata_o = q.ptr[7:0];
            OFS_PTR1: reg_rdata_o = q.ptr[15:8];
            OFS_PTR2: reg_rdata_o = q.ptr[23:16];
            OFS_PTR3: reg_rdata_o = q.ptr[31:24];
            default: ;
        endcase
    end

    assign go_o      = cmd_wr && reg_wdata_i[CMD_GO];
    assign stop_o    = cmd_wr && !reg_wdata_i[CMD_GO];
    assign go_dir_o  = reg_wdata_i[CMD_DIR];
    assign tbl_ptr_o = q.ptr;
    assign irq_o     = q.intr;

    // R10: a high drive interrupt line is seen as status and irq one cycle later.
    p_intr_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drv_intrq_i |=> irq_o);

    // R9: a bus error reported by the walker becomes a sticky status bit.
    p_fault_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> q.err);

    // R7: completion of the last descriptor becomes a sticky status bit.
    p_finish_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        finish_i |=> q.fin);

    // R11: writing one clears the error bit when no new error arrives.
    p_w1c_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && reg_wdata_i[ST_ERR] && !fault_i) |=> !q.err);

    // R11: writing zero keeps a set error bit.
    p_w0_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !reg_wdata_i[ST_ERR] && q.err) |=> q.err);
endmodule

// File: rtl/bmdma_walker.sv
module bmdma_walker
    import bmdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_i,
    input  logic        go_dir_i,
    input  logic        stop_i,
    input  logic [31:0] tbl_ptr_i,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [3:0]  mem_be_o,
    output logic [31:0] mem_wdata_o,
    input  logic        mem_ack_i,
    input  logic        mem_err_i,
    input  logic [31:0] mem_rdata_i,
    input  logic        drv_dmarq_i,
    output logic        drv_dmack_o,
    output logic [15:0] drv_wdata_o,
    input  logic [15:0] drv_rdata_i,
    output logic        active_o,
    output logic        fault_o,
    output logic        finish_o
);
    localparam int              REM_W = CNT_W + 1;
    localparam logic [REM_W-1:0] FULL  = REM_W'(1) << CNT_W;
    localparam logic [REM_W-1:0] UNIT  = REM_W'(2);

    typedef struct packed {
        walk_e            st;
        logic             to_mem;
        logic             last;
        logic [31:0]      dptr;
        logic [31:0]      cur;
        logic [REM_W-1:0] rem;
        logic [15:0]      half;
    } walk_t;

    walk_t q, d;

    logic             unit_done;
    logic [CNT_W-1:0] cnt_f;
    logic [3:0]       lane_be;
    logic [31:0]      lane_wdata;
    logic [15:0]      lane_half;
    logic             unused_hi;

    assign unused_hi = ^mem_rdata_i[LAST_BIT-1:CNT_W];

    bmdma_lane i_lane (
        .hi_sel_i (q.cur[1]),
        .half_i   (q.half),
        .word_i   (mem_rdata_i),
        .be_o     (lane_be),
        .wdata_o  (lane_wdata),
        .half_o   (lane_half)
    );

    always_comb begin
        d           = q;
        unit_done   = 1'b0;
        fault_o     = 1'b0;
        finish_o    = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = q.cur & 32'hFFFF_FFFC;
        mem_be_o    = lane_be;
        drv_dmack_o = 1'b0;
        cnt_f       = mem_rdata_i[CNT_W-1:0];
        cnt_f[0]    = 1'b0;

        case (q.st)
            W_IDLE: begin
                if (go_i) begin
                    d.st     = W_DESC_A;
                    d.dptr   = tbl_ptr_i;
                    d.to_mem = go_dir_i;
                end
            end
            W_DESC_A: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.dptr;
                mem_be_o   = 4'hF;
                if (mem_ack_i) begin
                    if (mem_err_i) begin
                        fault_o = 1'b1;
                        d.st    = W_IDLE;
                    end else begin
                        d.cur = {mem_rdata_i[31:1], 1'b0};
                        d.st  = W_DESC_C;
                    end
                end
            end
            W_DESC_C: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.dptr + 32'd4;
                mem_be_o   = 4'hF;
                if (mem_ack_i) begin
                    if (mem_err_i) begin
                        fault_o = 1'b1;
                        d.st    = W_IDLE;
                    end else begin
                        d.rem  = (cnt_f == '0) ? FULL : {1'b0, cnt_f};
                        d.last = mem_rdata_i[LAST_BIT];
                        d.dptr = q.dptr + 32'd8;
                        d.st   = q.to_mem ? W_DRV : W_MEM_RD;
                    end
                end
            end
            W_MEM_RD: begin
                mem_req_o = 1'b1;
                if (mem_ack_i) begin
                    if (mem_err_i) begin
                        fault_o = 1'b1;
                        d.st    = W_IDLE;
                    end else begin
                        d.half = lane_half;
                        d.st   = W_DRV;
                    end
                end
            end
            W_DRV: begin
                if (drv_dmarq_i) begin
                    drv_dmack_o = 1'b1;
                    if (q.to_mem) begin
                        d.half = drv_rdata_i;
                        d.st   = W_MEM_WR;
                    end else begin
                        unit_done = 1'b1;
                    end
                end
            end
            W_MEM_WR: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                if (mem_ack_i) begin
                    if (mem_err_i) begin
                        fault_o = 1'b1;
                        d.st    = W_IDLE;
                    end else begin
                        unit_done = 1'b1;
                    end
                end
            end
            default: d.st = W_IDLE;
        endcase

        if (unit_done) begin
            d.cur = q.cur + 32'd2;
            d.rem = q.rem - UNIT;
            if (q.rem == UNIT) begin
                if (q.last) begin
                    d.st     = W_IDLE;
                    finish_o = 1'b1;
                end else begin
                    d.st = W_DESC_A;
                end
            end else begin
                d.st = q.to_mem ? W_DRV : W_MEM_RD;
            end
        end

        if (stop_i) d.st = W_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= W_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_wdata_o = lane_wdata;
    assign drv_wdata_o = q.half;
    assign active_o    = (q.st != W_IDLE);

    // R13: acknowledge only answers a present request.
    p_ack_has_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        drv_dmack_o |-> drv_dmarq_i);

    // R13: one acknowledge per unit, never two cycles in a row.
    p_ack_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        drv_dmack_o |=> !drv_dmack_o);

    // R8: a stop command leaves the channel idle in the next cycle.
    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !active_o);

    // R9: an error response ends the transfer.
    p_fault_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i && mem_err_i) |=> !active_o);

    // R6: the remaining byte count stays a whole number of halfwords.
    p_rem_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> !q.rem[0]);

    // R7: once idle without a new start, no memory request is raised.
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !go_i) |=> !mem_req_o);
endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel
    import bmdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic        reg_we,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [31:0] mem_rdata,
    input  logic        drv_dmarq,
    output logic        drv_dmack,
    output logic [15:0] drv_wdata,
    input  logic [15:0] drv_rdata,
    input  logic        drv_intrq
);
    logic        go, go_dir, stop, active, fault, finish;
    logic [31:0] tbl_ptr;

    bmdma_regs i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr_i  (reg_addr),
        .reg_we_i    (reg_we),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .active_i    (active),
        .fault_i     (fault),
        .finish_i    (finish),
        .drv_intrq_i (drv_intrq),
        .go_o        (go),
        .go_dir_o    (go_dir),
        .stop_o      (stop),
        .tbl_ptr_o   (tbl_ptr),
        .irq_o       (irq)
    );

    bmdma_walker #(.CNT_W(CNT_W)) i_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .go_dir_i    (go_dir),
        .stop_i      (stop),
        .tbl_ptr_i   (tbl_ptr),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_be_o    (mem_be),
        .mem_wdata_o (mem_wdata),
        .mem_ack_i   (mem_ack),
        .mem_err_i   (mem_err),
        .mem_rdata_i (mem_rdata),
        .drv_dmarq_i (drv_dmarq),
        .drv_dmack_o (drv_dmack),
        .drv_wdata_o (drv_wdata),
        .drv_rdata_i (drv_rdata),
        .active_o    (active),
        .fault_o     (fault),
        .finish_o    (finish)
    );

    // R1: nothing is requested while reset is held.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !drv_dmack && !irq));
endmodule

// File: tb/test_bmdma_channel.sv
module test_bmdma_channel;
    localparam int CNT_W = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic        drv_dmarq;
    logic        drv_dmack;
    logic [15:0] drv_wdata, drv_rdata;
    logic        drv_intrq;

    int checks = 0;
    int bad = 0;
    int viol = 0;
    int k = 0;
    logic [31:0] cyc = 32'h0;
    logic k_clr = 1'b0;
    logic dq_en = 1'b0;
    logic pace = 1'b0;
    logic intr_lvl = 1'b0;
    logic err_arm = 1'b0;
    logic [31:0] err_addr = 32'h0;

    logic [31:0] mem   [0:511];
    logic [15:0] rx    [0:255];
    logic [15:0] ex_rx [0:255];
    logic [15:0] eh    [0:1023];

    always #5 clk = ~clk;

    bmdma_channel #(.CNT_W(CNT_W)) i_bmdma_channel (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .drv_dmarq(drv_dmarq), .drv_dmack(drv_dmack), .drv_wdata(drv_wdata),
        .drv_rdata(drv_rdata), .drv_intrq(drv_intrq)
    );

    function automatic logic [15:0] fill_half(input int a);
        return 16'((a >> 1) & 32'hFFFF) ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] pat(input int g);
        return 16'hC300 ^ 16'((g * 263) & 32'hFFFF);
    endfunction

    function automatic logic [15:0] mem_half(input int a);
        logic [31:0] w;
        w = mem[(a >> 2) & 511];
        return ((a & 2) != 0) ? w[31:16] : w[15:0];
    endfunction

    assign drv_dmarq = dq_en && !(pace && (cyc[1:0] == 2'b00));
    assign drv_rdata = pat(k);
    assign drv_intrq = intr_lvl;

    // memory model: one-cycle latency, optional error on one address
    always @(posedge clk) begin
        cyc <= cyc + 32'd1;
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_err   <= err_arm && (mem_addr == err_addr);
            mem_rdata <= mem[mem_addr[10:2]];
            if (mem_we && !(err_arm && (mem_addr == err_addr))) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[10:2]][8*b +: 8] = mem_wdata[8*b +: 8];
            end
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
    end

    // drive model: counts acknowledged units, records data sent to it
    always @(posedge clk) begin
        if (k_clr) k <= 0;
        else if (drv_dmack) begin
            rx[k & 255] = drv_wdata;
            k <= k + 1;
        end
    end

    always @(negedge clk) if (rst_n && drv_dmack && !drv_dmarq) viol++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] dat);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = dat;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] dat);
        reg_addr = a;
        #1;
        dat = reg_rdata;
    endtask

    task automatic mem_init();
        for (int i = 0; i < 512; i++)
            mem[i] = {fill_half(4 * i + 2), fill_half(4 * i)};
        for (int h = 0; h < 1024; h++) eh[h] = fill_half(2 * h);
    endtask

    task automatic clr_k();
        @(negedge clk);
        k_clr = 1'b1;
        @(negedge clk);
        k_clr = 1'b0;
    endtask

    task automatic set_ptr(input logic [31:0] p);
        wr(3'd4, p[7:0]);
        wr(3'd5, p[15:8]);
        wr(3'd6, p[23:16]);
        wr(3'd7, p[31:24]);
    endtask

    task automatic wait_k(input int n, input int lim);
        for (int c = 0; c < lim && k < n; c++) @(negedge clk);
    endtask

    task automatic run_case(input int dir, input int nd, input int v);
        int g, a, raw, bytes, nbad, fa, fe, hb;
        logic [31:0] ptr, cw;
        logic [7:0] s;
        mem_init();
        ptr = 32'h40 + 32'(v * 8);
        g = 0;
        for (int i = 0; i < nd; i++) begin
            a = 32'h100 + i * 32'h80 + (((v & 1) != 0) ? 2 : 0) + ((v == 2) ? 1 : 0);
            raw = (v == 3 && i == 0) ? 0 : ((v * 3 + i * 5) % 8) * 8 + 2 + ((v == 2) ? 1 : 0);
            bytes = ((raw & ~1) == 0) ? 64 : (raw & ~1);
            cw = 32'(raw) | ((v == 1) ? 32'h0000_7C00 : 32'h0) | ((i == nd - 1) ? 32'h8000_0000 : 32'h0);
            mem[(int'(ptr) + 8 * i) >> 2]     = 32'(a);
            mem[(int'(ptr) + 8 * i + 4) >> 2] = cw;
            for (int j = 0; j < bytes / 2; j++) begin
                hb = ((a & ~1) + 2 * j) >> 1;
                if (dir == 1) eh[hb] = pat(g);
                else          ex_rx[g] = fill_half(2 * hb);
                g++;
            end
        end
        pace  = (nd == 2);
        dq_en = 1'b1;
        clr_k();
        set_ptr(ptr);
        wr(3'd0, (dir == 1) ? 8'h09 : 8'h01);
        rd(3'd2, s);
        chk(s[0] == 1'b1, "R3 active after start", int'(s), 1);
        chk(mem_req && mem_addr == ptr, "R3 first fetch at table pointer", int'(mem_addr), int'(ptr));
        wait_k(g, 8000);
        repeat (20) @(negedge clk);
        chk(k == g, "R6/R7 unit count (no extra acks)", k, g);
        chk(!mem_req, "R7 no memory request after last", int'(mem_req), 0);
        rd(3'd2, s);
        chk(s[0] == 1'b0 && s[5] == 1'b1, "R7 idle with end bit", int'(s), 32'h20);
        @(negedge clk); intr_lvl = 1'b1;
        @(negedge clk); intr_lvl = 1'b0;
        rd(3'd2, s);
        chk(s[2:0] == 3'b100, "R12 good completion pattern", int'(s[2:0]), 4);
        chk(irq == 1'b1, "R10 irq follows interrupt bit", int'(irq), 1);
        nbad = 0; fa = 0; fe = 0;
        if (dir == 1) begin
            for (int h = 32'h80; h < 32'h140; h++)
                if (mem_half(2 * h) != eh[h]) begin
                    if (nbad == 0) begin fa = int'(mem_half(2 * h)); fe = int'(eh[h]); end
                    nbad++;
                end
            chk(nbad == 0, "R4 memory contents after drive-to-memory", fa, fe);
        end else begin
            for (int q = 0; q < g; q++)
                if (rx[q] != ex_rx[q]) begin
                    if (nbad == 0) begin fa = int'(rx[q]); fe = int'(ex_rx[q]); end
                    nbad++;
                end
            chk(nbad == 0, "R5 data delivered to drive", fa, fe);
        end
        wr(3'd2, 8'h26);
        rd(3'd2, s);
        chk(s == 8'h00, "R11 status cleared by ones", int'(s), 0);
        chk(irq == 1'b0, "R11 irq cleared", int'(irq), 0);
        dq_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] s;
        int ks;
        mem_init();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int a = 0; a < 8; a++) begin
            rd(3'(a), s);
            chk(s == 8'h00, "R1 register reset value", int'(s), 0);
        end
        chk(!irq && !mem_req && !drv_dmack, "R1 outputs idle", int'({irq, mem_req, drv_dmack}), 0);

        set_ptr(32'hDF9B_5713);
        rd(3'd4, s); chk(s == 8'h10, "R2 pointer byte 0 low bits zero", int'(s), 32'h10);
        rd(3'd5, s); chk(s == 8'h57, "R2 pointer byte 1", int'(s), 32'h57);
        rd(3'd6, s); chk(s == 8'h9B, "R2 pointer byte 2", int'(s), 32'h9B);
        rd(3'd7, s); chk(s == 8'hDF, "R2 pointer byte 3", int'(s), 32'hDF);
        wr(3'd0, 8'hF8);
        rd(3'd0, s); chk(s == 8'h08, "R2 command readback", int'(s), 8);
        rd(3'd1, s); chk(s == 8'h00, "R2 offset 1 reads zero", int'(s), 0);
        rd(3'd2, s); chk(s[0] == 1'b0, "R2 direction write alone does not start", int'(s), 0);

        for (int dir = 0; dir < 2; dir++)
            for (int nd = 1; nd <= 3; nd++)
                for (int v = 0; v < 4; v++)
                    run_case(dir, nd, v);

        // R8: stop in the middle of a 64-byte descriptor
        mem_init();
        mem[16] = 32'h0000_0100;
        mem[17] = 32'h8000_0000;
        pace = 1'b0; dq_en = 1'b1;
        clr_k();
        set_ptr(32'h40);
        wr(3'd0, 8'h09);
        wait_k(5, 200);
        wr(3'd0, 8'h08);
        rd(3'd2, s);
        chk(s[0] == 1'b0, "R8 stop clears active", int'(s), 0);
        ks = k;
        repeat (30) @(negedge clk);
        chk(k == ks, "R8 no acknowledge after stop", k, ks);
        chk(!mem_req, "R8 no memory request after stop", int'(mem_req), 0);
        chk(ks < 32, "R8 transfer cut short", ks, 5);
        dq_en = 1'b0;

        // R9: error on the third unit's write
        mem_init();
        mem[16] = 32'h0000_0100;
        mem[17] = 32'h8000_0020;
        err_addr = 32'h104; err_arm = 1'b1;
        dq_en = 1'b1;
        clr_k();
        wr(3'd2, 8'h26);
        wr(3'd0, 8'h09);
        for (int c = 0; c < 300; c++) begin
            rd(3'd2, s);
            if (s[1]) break;
            @(negedge clk);
        end
        rd(3'd2, s);
        chk(s[1] == 1'b1 && s[0] == 1'b0, "R9 error set and idle", int'(s), 2);
        repeat (20) @(negedge clk);
        chk(k == 3, "R9 no units after error", k, 3);
        chk(mem_half(32'h104) == fill_half(32'h104), "R9 failed word untouched", int'(mem_half(32'h104)), int'(fill_half(32'h104)));
        chk(mem_half(32'h102) == pat(1), "R4 unit before error stored", int'(mem_half(32'h102)), int'(pat(1)));
        err_arm = 1'b0; dq_en = 1'b0;
        wr(3'd2, 8'h00);
        rd(3'd2, s);
        chk(s[1] == 1'b1, "R11 writing zero keeps error", int'(s), 2);
        wr(3'd2, 8'h02);
        rd(3'd2, s);
        chk(s[1] == 1'b0, "R11 writing one clears error", int'(s), 0);

        // R10/R11: held interrupt wins over clear
        @(negedge clk); intr_lvl = 1'b1;
        wr(3'd2, 8'h04);
        rd(3'd2, s);
        chk(s[2] == 1'b1 && irq, "R10 held interrupt keeps bit set", int'(s), 4);
        intr_lvl = 1'b0;
        wr(3'd2, 8'h04);
        rd(3'd2, s);
        chk(s[2] == 1'b0 && !irq, "R11 interrupt clears once line is low", int'(s), 0);

        chk(viol == 0, "R13 acknowledge only with request", viol, 0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule